// File: doc/BRIEF.md
# Dual-Issue Pairing and Bus Steering Unit

This unit sits between an instruction buffer and the execution units of a two-wide in-order core. Every cycle it is shown the two oldest instructions that have not yet issued. Each one comes with a pre-decoded class and a few flags. The unit decides whether the younger instruction may issue in the same cycle as the older one. It then places the issuing instructions onto three instruction buses: integer ALU 0, integer ALU 1 and the floating-point bus. Memory operations use an integer ALU bus to form their address.

The decision follows a fixed set of pairing rules:

- The two instructions must be in different classes, or both must be integer operations.
- A branch may close a pair but may never open one.
- Only one instruction per cycle may use the single shifter or the single condition tester.
- A condition-testing instruction may only be joined by a floating-point instruction.
- A younger instruction that lies beyond a cache-line or page boundary may only join as floating point.

Pairs need no double-word alignment, so the unit sees only "older" and "younger" candidates and never slot parity. When the pair is refused, the feeder consumes one instruction and presents the younger one as the older candidate next cycle. The issue count tells the feeder how many instructions to consume. All outputs are registered, one cycle after the candidates are presented.

Top module: `pair_issue_steer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, issue_cnt, bus_vld, yng_first and kill_old_wb are all zero.
- R2: The outputs reflect the candidates presented one clock earlier. issue_cnt is 0 when old_vld is low. issue_cnt is 1 when old_vld is high and yng_vld is low.
- R3: Class codes are 0 for integer, 1 for memory and 2 for floating point. Two valid candidates in different classes, or both integer, pair (issue_cnt 2) unless a later rule forbids it. Two memory candidates, or two floating-point candidates, never pair.
- R4: A branch flag on the older candidate forbids pairing. A branch flag on the younger candidate does not.
- R5: If both candidates carry a shift or condition-test flag (in any combination), they do not pair.
- R6: An older candidate with the condition-test flag pairs only with a floating-point younger candidate.
- R7: A younger candidate with the boundary flag set pairs only if it is floating point.
- R8: The bus_vld bits are bit 0 for ALU 0, bit 1 for ALU 1 and bit 2 for the floating-point bus. A floating-point instruction goes to bit 2. A lone non-floating-point instruction goes to ALU 0. Of two non-floating-point instructions, the older goes to ALU 0 unless the younger has a shift or condition-test flag, in which case the younger goes to ALU 0.
- R9: The number of set bus_vld bits equals issue_cnt. yng_first is 1 exactly when the younger instruction of an issued pair sits on a lower-numbered bus than the older one.
- R10: kill_old_wb is 1 exactly when a pair issues and both candidates name the same target register, so that the younger write alone survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| old_vld | input | 1 | Older candidate present |
| old_cls | input | 2 | Older class: 0 integer, 1 memory, 2 floating point |
| old_br | input | 1 | Older candidate is a branch |
| old_shf | input | 1 | Older uses shifter (shift/extract/deposit) |
| old_tc | input | 1 | Older uses condition tester |
| old_tgt | input | REG_W | Older target register |
| yng_vld | input | 1 | Younger candidate present |
| yng_cls | input | 2 | Younger class, same coding |
| yng_br | input | 1 | Younger candidate is a branch |
| yng_shf | input | 1 | Younger uses shifter |
| yng_tc | input | 1 | Younger uses condition tester |
| yng_xbnd | input | 1 | Younger lies across a line or page boundary |
| yng_tgt | input | REG_W | Younger target register |
| issue_cnt | output | 2 | Instructions issued: 0, 1 or 2 |
| bus_vld | output | 3 | Bus valid bits: ALU0, ALU1, FP |
| yng_first | output | 1 | Younger sits on the lower-numbered bus |
| kill_old_wb | output | 1 | Suppress the older write to a shared target |

## Verification
The bench focuses on the asymmetric cases. A design that swapped the branch rule would pair a branch with its successor. A design that checked the condition tester on the wrong candidate would let a memory operation follow a test instruction. A design that ignored the boundary flag would pair an integer op across a line.

Steering is probed with a shift in the younger slot, which must pull that instruction onto ALU 0 and raise yng_first. A design that always put the older instruction on ALU 0 would place a shift on a unit without a shifter. Shared targets are tried both paired and unpaired, because suppressing the older write when no pair issues would lose a result.

// File: rtl/pair_pkg.sv
package pair_pkg;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_MEM = 2'd1,
        CLS_FP  = 2'd2
    } icls_e;

    localparam int BUS_N   = 3;
    localparam int BUS_A0  = 0;
    localparam int BUS_A1  = 1;
    localparam int BUS_FPB = 2;

    typedef struct packed {
        logic vld;
        logic [1:0] cls;
        logic br;
        logic shf;
        logic tc;
        logic xbnd;
    } cand_t;

endpackage

// File: rtl/pair_check.sv
module pair_check
    import pair_pkg::*;
(
    input  cand_t old_c,
    input  cand_t yng_c,
    output logic  pair_ok
);
    logic group_ok;
    logic unit_clash;
    logic tc_block;
    logic bnd_block;

    always_comb begin
        group_ok   = (old_c.cls != yng_c.cls) || (old_c.cls == CLS_INT);
        unit_clash = (old_c.shf || old_c.tc) && (yng_c.shf || yng_c.tc);
        tc_block   = old_c.tc && (yng_c.cls != CLS_FP);
        bnd_block  = yng_c.xbnd && (yng_c.cls != CLS_FP);
        pair_ok    = old_c.vld && yng_c.vld && group_ok && !old_c.br
                     && !unit_clash && !tc_block && !bnd_block;
    end
endmodule

// File: rtl/pair_steer.sv
module pair_steer
    import pair_pkg::*;
(
    input  cand_t              old_c,
    input  cand_t              yng_c,
    input  logic               pair_ok,
    output logic [BUS_N-1:0]   bus,
    output logic               yfirst
);
    logic old_fp;
    logic yng_fp;
    logic yng_unit;

    always_comb begin
        old_fp   = (old_c.cls == CLS_FP);
        yng_fp   = (yng_c.cls == CLS_FP);
        yng_unit = yng_c.shf || yng_c.tc;
        bus      = '0;
        yfirst   = 1'b0;
        if (old_c.vld) begin
            if (!pair_ok) begin
                bus[old_fp ? BUS_FPB : BUS_A0] = 1'b1;
            end else if (old_fp) begin
                bus[BUS_FPB] = 1'b1;
                bus[BUS_A0]  = 1'b1;
                yfirst       = 1'b1;
            end else if (yng_fp) begin
                bus[BUS_A0]  = 1'b1;
                bus[BUS_FPB] = 1'b1;
            end else begin
                bus[BUS_A0]  = 1'b1;
                bus[BUS_A1]  = 1'b1;
                yfirst       = yng_unit;
            end
        end
    end
endmodule

// File: rtl/pair_issue_steer.sv
module pair_issue_steer
    import pair_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             old_vld,
    input  logic [1:0]       old_cls,
    input  logic             old_br,
    input  logic             old_shf,
    input  logic             old_tc,
    input  logic [REG_W-1:0] old_tgt,
    input  logic             yng_vld,
    input  logic [1:0]       yng_cls,
    input  logic             yng_br,
    input  logic             yng_shf,
    input  logic             yng_tc,
    input  logic             yng_xbnd,
    input  logic [REG_W-1:0] yng_tgt,
    output logic [1:0]       issue_cnt,
    output logic [2:0]       bus_vld,
    output logic             yng_first,
    output logic             kill_old_wb
);
    typedef struct packed {
        logic [1:0]       cnt;
        logic [BUS_N-1:0] bus;
        logic             yf;
        logic             kill;
    } out_t;

    cand_t            old_c;
    cand_t            yng_c;
    logic             pair_ok;
    logic [BUS_N-1:0] bus_c;
    logic             yf_c;
    out_t             st_d;
    out_t             st_q;

    assign old_c = '{vld: old_vld, cls: old_cls, br: old_br, shf: old_shf,
                     tc: old_tc, xbnd: 1'b0};
    assign yng_c = '{vld: yng_vld, cls: yng_cls, br: yng_br, shf: yng_shf,
                     tc: yng_tc, xbnd: yng_xbnd};

    pair_check u_check (
        .old_c   (old_c),
        .yng_c   (yng_c),
        .pair_ok (pair_ok)
    );

    pair_steer u_steer (
        .old_c   (old_c),
        .yng_c   (yng_c),
        .pair_ok (pair_ok),
        .bus     (bus_c),
        .yfirst  (yf_c)
    );

    always_comb begin
        st_d      = '0;
        st_d.cnt  = !old_vld ? 2'd0 : (pair_ok ? 2'd2 : 2'd1);
        st_d.bus  = bus_c;
        st_d.yf   = yf_c;
        st_d.kill = pair_ok && (old_tgt == yng_tgt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign issue_cnt   = st_q.cnt;
    assign bus_vld     = st_q.bus;
    assign yng_first   = st_q.yf;
    assign kill_old_wb = st_q.kill;

    AST_BUS_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bus_vld) == issue_cnt); // R9
    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !old_vld |=> (issue_cnt == 2'd0)); // R2
    AST_BRANCH_NOT_OPENER: assert property (@(posedge clk) disable iff (!rst_n)
        (old_vld && old_br) |=> (issue_cnt != 2'd2)); // R4
    AST_TEST_THEN_NONFP: assert property (@(posedge clk) disable iff (!rst_n)
        (old_vld && old_tc && yng_cls != CLS_FP) |=> (issue_cnt != 2'd2)); // R6
    AST_BOUNDARY_NONFP: assert property (@(posedge clk) disable iff (!rst_n)
        (yng_xbnd && yng_cls != CLS_FP) |=> (issue_cnt != 2'd2)); // R7
    AST_SINGLE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((old_shf || old_tc) && (yng_shf || yng_tc)) |=> (issue_cnt != 2'd2)); // R5
    AST_KILL_ONLY_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        kill_old_wb |-> (issue_cnt == 2'd2)); // R10
    AST_ORDER_ONLY_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        yng_first |-> (issue_cnt == 2'd2)); // R9
endmodule

// File: tb/pair_issue_steer_bench.sv
module pair_issue_steer_bench;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic o_v = 0, o_br = 0, o_s = 0, o_t = 0;
    logic [1:0] o_c = 0;
    logic [RW-1:0] o_g = 0;
    logic y_v = 0, y_br = 0, y_s = 0, y_t = 0, y_x = 0;
    logic [1:0] y_c = 0;
    logic [RW-1:0] y_g = 0;
    logic [1:0] issue_cnt;
    logic [2:0] bus_vld;
    logic yng_first, kill_old_wb;

    int checks = 0;
    int errors = 0;
    logic [1:0] e_cnt;
    logic [2:0] e_bus;
    logic e_yf, e_kill;
    string e_tag;

    always #10 clk = ~clk;

    pair_issue_steer #(.REG_W(RW)) u_pair_issue_steer (
        .clk(clk), .rst_n(rst_n),
        .old_vld(o_v), .old_cls(o_c), .old_br(o_br), .old_shf(o_s),
        .old_tc(o_t), .old_tgt(o_g),
        .yng_vld(y_v), .yng_cls(y_c), .yng_br(y_br), .yng_shf(y_s),
        .yng_tc(y_t), .yng_xbnd(y_x), .yng_tgt(y_g),
        .issue_cnt(issue_cnt), .bus_vld(bus_vld),
        .yng_first(yng_first), .kill_old_wb(kill_old_wb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model();
        logic pr;
        int io, iy;
        pr = 1'b0;
        if (!o_v)                                  e_tag = "R2";
        else if (!y_v)                             e_tag = "R2";
        else if (o_c == y_c && o_c != 2'd0)        e_tag = "R3";
        else if (o_br)                             e_tag = "R4";
        else if ((o_s || o_t) && (y_s || y_t))     e_tag = "R5";
        else if (o_t && y_c != 2'd2)               e_tag = "R6";
        else if (y_x && y_c != 2'd2)               e_tag = "R7";
        else begin pr = 1'b1; e_tag = y_br ? "R4" : "R3"; end
        e_cnt = !o_v ? 2'd0 : (pr ? 2'd2 : 2'd1);
        e_bus = 3'b000;
        e_yf  = 1'b0;
        if (o_v) begin
            io = (o_c == 2'd2) ? 2 : ((pr && y_c != 2'd2 && (y_s || y_t)) ? 1 : 0);
            e_bus[io] = 1'b1;
            if (pr) begin
                iy = (y_c == 2'd2) ? 2 : ((o_c == 2'd2 || y_s || y_t) ? 0 : 1);
                e_bus[iy] = 1'b1;
                e_yf = (iy < io);
            end
        end
        e_kill = pr && (o_g == y_g);
    endtask

    task automatic step();
        model();
        @(posedge clk);
        @(negedge clk);
        chk({e_tag, " count"}, issue_cnt, e_cnt);
        chk("R8 bus", bus_vld, e_bus);
        chk("R9 order", yng_first, e_yf);
        chk("R10 kill", kill_old_wb, e_kill);
    endtask

    task automatic set(input logic ov, input logic [1:0] oc, input logic ob, input logic os,
                       input logic ot, input logic yv, input logic [1:0] yc, input logic yb,
                       input logic ys, input logic yt, input logic yx,
                       input logic [RW-1:0] og, input logic [RW-1:0] yg);
        o_v = ov; o_c = oc; o_br = ob; o_s = os; o_t = ot; o_g = og;
        y_v = yv; y_c = yc; y_br = yb; y_s = ys; y_t = yt; y_x = yx; y_g = yg;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        set(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 2);
        @(negedge clk);
        chk("R1 reset count", issue_cnt, 0);
        chk("R1 reset bus", bus_vld, 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 after release", {yng_first, kill_old_wb}, 0);
        @(negedge clk);
        // R3 int+int pair; two memory ops do not
        set(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 2); step();
        set(1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1, 2); step();
        set(1, 2, 0, 0, 0, 1, 2, 0, 0, 0, 0, 1, 2); step();
        // R4 branch older refused, branch younger allowed
        set(1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 2); step();
        set(1, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 1, 2); step();
        // R5 shifter and tester clash
        set(1, 0, 0, 1, 0, 1, 0, 0, 0, 1, 0, 1, 2); step();
        // R6 tester followed by memory refused, by FP allowed
        set(1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 1, 2); step();
        set(1, 0, 0, 0, 1, 1, 2, 0, 0, 0, 0, 1, 2); step();
        // R7 boundary: FP younger pairs, integer younger does not
        set(1, 1, 0, 0, 0, 1, 2, 0, 0, 0, 1, 1, 2); step();
        set(1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 1, 1, 2); step();
        // R8 younger shift steered to ALU 0, older to ALU 1
        set(1, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 1, 2); step();
        // R9 FP older + integer younger: younger on lower bus
        set(1, 2, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 2); step();
        // R10 shared target paired and unpaired
        set(1, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 7, 7); step();
        set(1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 7, 7); step();
        // R2 idle and lone older
        set(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 2); step();
        set(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1); step();
        for (int i = 0; i < 400; i++) begin
            logic [1:0] oc, yc;
            oc = 2'($urandom_range(0, 2));
            yc = 2'($urandom_range(0, 2));
            set($urandom_range(0, 7) != 0, oc, oc == 0 && $urandom_range(0, 3) == 0,
                $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
                $urandom_range(0, 7) != 0, yc, yc == 0 && $urandom_range(0, 3) == 0,
                $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
                $urandom_range(0, 4) == 0,
                RW'($urandom_range(0, 3)), RW'($urandom_range(0, 3)));
            step();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule